// File: doc/BRIEF.md
# Collision-Vector Initiation Controller

This block gates the start of new tasks into a non-linear pipeline whose stages may be reused by a task over several cycles. The stage reuse pattern is summarised as an initial collision vector: bit k is 1 when two tasks started k cycles apart would both need some stage in the same cycle. Bit 0 is always treated as 1. The controller keeps the current collision vector as its state and counts the cycles since the last accepted start. A pending start request is granted only when the bit of the current vector selected by that count is 0, or when the count has reached the vector width.

On each grant the state becomes the current vector shifted toward bit 0 by the elapsed latency, with the initial collision vector ORed in, and the latency count restarts. A request that arrives at a forbidden latency simply sees grant low; if the requester holds it, grant rises at the first allowed latency. The result is greedy scheduling: each task starts at the earliest latency that causes no stage conflict. The initial collision vector is taken from an input port while reset is active and stays fixed until the next reset.

Top module: `cvInitCtrl`

## Requirements
- R1: While reset is active the controller stores initVec with bit 0 forced to 1 as its initial vector. In the first cycle after reset, stateVec equals that stored vector and latency equals VEC_W.
- R2: grant is high in a cycle exactly when startReq is high and either latency is at least VEC_W or bit number `latency` of stateVec is 0. grant responds in the same cycle as startReq.
- R3: After a cycle with grant high, stateVec equals (previous stateVec shifted right by the previous latency) ORed with the stored initial vector.
- R4: After a cycle with grant high, latency is 1. In every other cycle, latency rises by 1 until it saturates at VEC_W.
- R5: stateVec holds its value in every cycle without a grant. This includes requests refused at a forbidden latency.
- R6: When latency has saturated at VEC_W, any request is granted, and the following stateVec equals the stored initial vector.
- R7: Changes on initVec after reset is released have no effect on the stored initial vector or on the state.
- R8: A request held high is granted at the first allowed latency. With initial vector 10101 (binary, bit 4 down to bit 0), a held request from the 10111 state is granted every 3 cycles and the state stays 10111. From a reset state of 10101, a held request is granted with alternating latencies 1 and 5.
- R9: Bit 0 of the stored initial vector and of stateVec is always 1, even when initVec bit 0 is driven 0 during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low; initVec is captured while it is low |
| startReq | input | 1 | Request to start a new task in this cycle |
| initVec | input | VEC_W | Initial collision vector, bit k set when latency k is forbidden |
| grant | output | 1 | Start accepted this cycle (combinational from startReq) |
| stateVec | output | VEC_W | Current collision vector |
| latency | output | $clog2(VEC_W+1) | Cycles since the last accepted start, saturating at VEC_W |

## Verification
The bench builds the block with the default width of 5, so the latency counter needs 3 bits. At this width the counter reaches both its saturation value and every bit index of the vector within a few cycles. That width covers the textbook 10101 table, including its 11111 and 10111 states, the 1/5 greedy alternation and the latency-3 loop. It also covers an all-ones vector that allows only saturated starts, a vector whose bit 0 is driven low, and changes to initVec made outside reset.

// File: rtl/cvPkg.sv
package cvPkg;
  // Strobes from the control to the datapath, one cycle's worth.
  typedef struct packed {
    logic accept;   // a start is granted this cycle
    logic advance;  // no start and latency not yet saturated
  } cvStrobe_t;
endpackage

// File: rtl/cvShifter.sv
module cvShifter #(
  parameter int VEC_W = 5,
  parameter int CNT_W = $clog2(VEC_W + 1)
) (
  input  logic [VEC_W-1:0] curVec,
  input  logic [CNT_W-1:0] shiftAmt,
  input  logic [VEC_W-1:0] mergeVec,
  output logic [VEC_W-1:0] nextVec
);
  logic [VEC_W-1:0] shifted;

  // One mux per bit: bit b takes bit b+k of the current vector when the
  // shift amount is k, and 0 once b+k runs past the top of the vector.
  for (genvar b = 0; b < VEC_W; b++) begin : gBit
    logic pick;
    always_comb begin
      pick = 1'b0;
      for (int k = 0; k <= VEC_W; k++) begin
        if (shiftAmt == CNT_W'(k) && (b + k) < VEC_W) begin
          pick = curVec[(b + k) % VEC_W];
        end
      end
    end
    assign shifted[b] = pick;
  end

  assign nextVec = shifted | mergeVec;
endmodule

// File: rtl/cvCtrl.sv
module cvCtrl
  import cvPkg::*;
#(
  parameter int VEC_W = 5,
  parameter int CNT_W = $clog2(VEC_W + 1)
) (
  input  logic             startReq,
  input  logic [VEC_W-1:0] stateVec,
  input  logic [CNT_W-1:0] latency,
  output logic             grant,
  output cvStrobe_t        strobe
);
  logic saturated;
  logic blocked;

  assign saturated = (latency >= CNT_W'(VEC_W));

  // Select the collision bit addressed by the elapsed latency.
  always_comb begin
    blocked = 1'b0;
    for (int i = 0; i < VEC_W; i++) begin
      if (latency == CNT_W'(i)) begin
        blocked = stateVec[i];
      end
    end
  end

  assign grant = startReq && (saturated || !blocked);

  always_comb begin
    strobe.accept  = grant;
    strobe.advance = !grant && !saturated;
  end
endmodule

// File: rtl/cvDatapath.sv
module cvDatapath
  import cvPkg::*;
#(
  parameter int VEC_W = 5,
  parameter int CNT_W = $clog2(VEC_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [VEC_W-1:0] initVec,
  input  cvStrobe_t        strobe,
  output logic [VEC_W-1:0] stateVec,
  output logic [CNT_W-1:0] latency,
  output logic [VEC_W-1:0] icvHeld
);
  localparam logic [CNT_W-1:0] LAT_MAX = CNT_W'(VEC_W);
  localparam logic [CNT_W-1:0] LAT_ONE = CNT_W'(1);
  localparam logic [VEC_W-1:0] ZERO_BIT = VEC_W'(1);

  logic [VEC_W-1:0] icvReg;
  logic [VEC_W-1:0] stateReg;
  logic [CNT_W-1:0] latReg;
  logic [VEC_W-1:0] nextVec;

  cvShifter #(.VEC_W(VEC_W), .CNT_W(CNT_W)) u_shift (
    .curVec  (stateReg),
    .shiftAmt(latReg),
    .mergeVec(icvReg),
    .nextVec (nextVec)
  );

  // Initial vector: captured only while reset is held, bit 0 forced.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      icvReg <= initVec | ZERO_BIT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateReg <= initVec | ZERO_BIT;
    end else if (strobe.accept) begin
      stateReg <= nextVec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latReg <= LAT_MAX;
    end else if (strobe.accept) begin
      latReg <= LAT_ONE;
    end else if (strobe.advance) begin
      latReg <= latReg + LAT_ONE;
    end
  end

  assign stateVec = stateReg;
  assign latency  = latReg;
  assign icvHeld  = icvReg;
endmodule

// File: rtl/cvInitCtrl.sv
module cvInitCtrl
  import cvPkg::*;
#(
  parameter int VEC_W = 5,
  localparam int CNT_W = $clog2(VEC_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [VEC_W-1:0] initVec,
  output logic             grant,
  output logic [VEC_W-1:0] stateVec,
  output logic [CNT_W-1:0] latency
);
  cvStrobe_t        strobe;
  logic [VEC_W-1:0] icvHeld;

  cvCtrl #(.VEC_W(VEC_W), .CNT_W(CNT_W)) u_ctrl (
    .startReq(startReq),
    .stateVec(stateVec),
    .latency (latency),
    .grant   (grant),
    .strobe  (strobe)
  );

  cvDatapath #(.VEC_W(VEC_W), .CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .initVec (initVec),
    .strobe  (strobe),
    .stateVec(stateVec),
    .latency (latency),
    .icvHeld (icvHeld)
  );
endmodule

// File: rtl/cvCheck.sv
module cvCheck #(
  parameter int VEC_W = 5,
  localparam int CNT_W = $clog2(VEC_W + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             startReq,
  input logic             grant,
  input logic [VEC_W-1:0] stateVec,
  input logic [CNT_W-1:0] latency,
  input logic [VEC_W-1:0] icvHeld
);
  localparam logic [CNT_W-1:0] LAT_MAX = CNT_W'(VEC_W);

  // R2
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    grant |-> startReq);

  // R6
  sat_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && latency == LAT_MAX) |-> grant);

  // R6
  sat_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grant && latency == LAT_MAX) |=> stateVec == $past(icvHeld));

  // R4
  lat_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    grant |=> latency == CNT_W'(1));

  // R4
  lat_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!grant && latency < LAT_MAX) |=> latency == $past(latency) + CNT_W'(1));

  // R4
  lat_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    latency <= LAT_MAX && latency != '0);

  // R5
  state_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !grant |=> $stable(stateVec));

  // R3
  merge_chk: assert property (@(posedge clk) disable iff (!rstN)
    grant |=> (stateVec & $past(icvHeld)) == $past(icvHeld));

  // R9
  bit_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    stateVec[0] && icvHeld[0]);

  // R7
  icv_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(icvHeld));
endmodule

bind cvInitCtrl cvCheck #(.VEC_W(VEC_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .startReq(startReq),
  .grant   (grant),
  .stateVec(stateVec),
  .latency (latency),
  .icvHeld (icvHeld)
);

// File: tb/cvInitCtrl_bench.sv
module cvInitCtrl_bench;
  localparam int W  = 5;
  localparam int CW = $clog2(W + 1);

  typedef struct {
    logic          g;
    logic [W-1:0]  s;
    logic [CW-1:0] l;
    string         tag;
  } expItem_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic [W-1:0]  initVec = '0;
  logic          grant;
  logic [W-1:0]  stateVec;
  logic [CW-1:0] latency;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  expItem_t expQ[$];

  // Reference model state, written only by the driver.
  logic [W-1:0] mIcv;
  logic [W-1:0] mState;
  int           mLat;

  always #4 clk = ~clk;

  cvInitCtrl #(.VEC_W(W)) u_cvInitCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(startReq),
    .initVec (initVec),
    .grant   (grant),
    .stateVec(stateVec),
    .latency (latency)
  );

  task automatic doReset(input logic [W-1:0] vec);
    @(negedge clk);
    #1;
    rstN = 1'b0;
    startReq = 1'b0;
    initVec = vec;
    repeat (3) @(negedge clk);
    #1;
    rstN = 1'b1;
    mIcv = vec | W'(1);
    mState = mIcv;
    mLat = W;
  endtask

  // Drive one cycle and push what the outputs must show in it.
  task automatic step(input logic req, input string tag);
    expItem_t it;
    logic g;
    @(negedge clk);
    #1;
    startReq = req;
    g = req && (mLat >= W || !mState[mLat % W]);
    it.g = g;
    it.s = mState;
    it.l = CW'(mLat);
    it.tag = tag;
    expQ.push_back(it);
    if (g) begin
      mState = (mLat >= W) ? mIcv : ((mState >> mLat) | mIcv);
      mLat = 1;
    end else if (mLat < W) begin
      mLat = mLat + 1;
    end
  endtask

  task automatic run(input logic req, input int n, input string tag);
    for (int i = 0; i < n; i++) step(req, tag);
  endtask

  // Monitor: compares just before the next rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        checks++;
        if (grant !== e.g || stateVec !== e.s || latency !== e.l) begin
          errors++;
          $display("FAIL %s: got grant=%b state=%b lat=%0d, expected grant=%b state=%b lat=%0d",
                   e.tag, grant, stateVec, latency, e.g, e.s, e.l);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got run still active, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state with the 10101 table
    doReset(5'b10101);
    run(1'b0, 2, "R1 reset state");
    // R8: greedy alternation 1,5 from reset state
    run(1'b1, 14, "R8 held request 1/5 cycle");
    // R4 / R6: idle until saturation, then a start restores initial vector
    run(1'b0, 7, "R4 latency saturates");
    step(1'b1, "R6 saturated grant");
    run(1'b0, 2, "R4 latency counts");
    // R2: latency 3 on 10101 is allowed, leads to 10111
    step(1'b1, "R2 grant at latency 3");
    // R5 / R2: pulse at forbidden latency 1 refused, state held
    step(1'b1, "R2 refused at latency 1");
    step(1'b0, "R5 state held after refusal");
    // R8: latency 3 loop in 10111
    run(1'b1, 10, "R8 latency-3 loop");
    // R3: enter 11111 via latency 1 from 10101
    run(1'b0, 6, "R4 saturate again");
    step(1'b1, "R3 start");
    step(1'b1, "R3 shift merge to 11111");
    run(1'b1, 6, "R2 all forbidden until saturation");
    // R7: initVec change outside reset is ignored
    run(1'b0, 1, "R7 setup");
    initVec = 5'b00011;
    run(1'b0, 6, "R7 idle");
    step(1'b1, "R7 start keeps stored vector");
    step(1'b1, "R7 latency 1 still allowed");
    run(1'b0, 2, "R7 state from old vector");
    // R9: bit 0 forced during reset
    doReset(5'b01000);
    run(1'b0, 1, "R9 bit0 forced");
    run(1'b1, 12, "R9 held request");
    // R2 / R6: all-ones vector allows only saturated starts
    doReset(5'b11111);
    run(1'b1, 13, "R6 all-ones vector");
    // R3: another vector with mixed latencies
    doReset(5'b10011);
    run(1'b1, 12, "R3 mixed vector");
    run(1'b0, 1, "R3 drain");
    @(negedge clk);
    #5;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule